// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer whose control byte is protected by a short unlock handshake. Software writes one control byte that carries an enable bit, a three-bit period select and a change-enable bit, and it can read the byte back at any time. While the watchdog is enabled, a prescaled counter runs toward the selected time-out. A kick input restarts the count. If the count expires, the block raises a reset request for exactly one clock cycle and then starts counting again.

Some changes to the control byte are guarded. A guarded change takes effect only when two writes arrive close together. The first write sets both the change-enable bit and the enable bit. The second write clears the change-enable bit and must arrive within the four clock cycles that follow the first. The static two-bit protection level input decides which changes are guarded. Level 0 guards only switching the watchdog off. Level 1 guards switching off and changing the period. Level 2 keeps the watchdog on permanently and guards the period.

Top module: `wdog_guarded`

## Requirements
- R1: After a synchronous reset, the read port returns 0x00 when the level input is 0 or 1 and 0x08 when it is 2 or 3. The reset request stays low.
- R2: The control byte is laid out as follows. Bits [2:0] hold the period select. Bit 3 is the enable bit. Bit 4 is the change-enable bit, and on reads it shows whether the unlock window is open. Bits [7:5] read as zero and are ignored on writes.
- R3: A write with bit 4 and bit 3 both set opens the unlock window. Bit 4 then reads as 1 for the next four cycles and clears by itself unless a completing write closes it first.
- R4: A completing write is a write with bit 4 clear while the window is open. It applies the guarded enable and period values and closes the window. A guarded value written after the window has closed is dropped, and the old value is kept.
- R5: At level 0, a plain write can set the enable bit and can change the period. Clearing the enable bit needs a completing write.
- R6: At level 1, a plain write can set the enable bit. Clearing the enable bit and changing the period both need a completing write. The period carried by the opening write is not applied.
- R7: At levels 2 and 3, the enable bit always reads as 1. A period change needs a completing write, and the enable value in that write is ignored.
- R8: While enabled, the reset request goes high for exactly one cycle, 2^(BASE_EXP+period select) × PRESC_DIV clock edges after the edge that enabled or restarted the count. Counting then restarts from zero.
- R9: A kick restarts the count. The next reset request comes the full time-out after the clock edge at which the kick was sampled.
- R10: An accepted write that changes the period-select value restarts the count.
- R11: While the watchdog is disabled, the counter stays at zero and no reset request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| level_i | input | 2 | Static protection level (0, 1, 2; 3 behaves as 2) |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte write data |
| rd_data_o | output | 8 | Current control byte |
| kick_i | input | 1 | Restart the time-out count |
| wdt_reset_o | output | 1 | One-cycle reset request on time-out |

## Verification
Register results appear on the read port right after the clock edge that samples the write. The bench therefore reads the port at the falling edge that follows each write.

The reset request is registered. With PRESC_DIV = P and time-out L, it is high only in the cycle that follows the L×P-th edge after the enabling write, kick or period change. The bench counts falling edges from that reference edge. It checks that the output is low on every earlier one, high on the expected one and low again on the next.

Window tests place the completing write on the fourth cycle, where it must be accepted, and after the window has lapsed, where it must be dropped.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Control byte layout
    localparam int CTRL_W     = 8;
    localparam int PSEL_W     = 3;
    localparam int EN_BIT     = 3;
    localparam int CHG_BIT    = 4;

    // Cycles the unlock window stays open after an opening write
    localparam int UNLOCK_WINDOW = 4;
    localparam int WIN_W         = $clog2(UNLOCK_WINDOW + 1);

    typedef enum logic [1:0] {
        LVL_OPEN    = 2'd0,
        LVL_GUARDED = 2'd1,
        LVL_LOCKED  = 2'd2
    } level_e;

    typedef struct packed {
        logic              chg;
        logic              en;
        logic [PSEL_W-1:0] psel;
    } ctrl_t;

    function automatic level_e decode_level(input logic [1:0] raw);
        case (raw)
            2'd0:    return LVL_OPEN;
            2'd1:    return LVL_GUARDED;
            default: return LVL_LOCKED;
        endcase
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] b);
        ctrl_t c;
        c.chg  = b[CHG_BIT];
        c.en   = b[EN_BIT];
        c.psel = b[PSEL_W-1:0];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] pack_ctrl(input ctrl_t c);
        return {3'b000, c.chg, c.en, c.psel};
    endfunction

endpackage

// File: rtl/wdog_ctrl_guard.sv
module wdog_ctrl_guard
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  level_e            level,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic              restart
);

    logic [WIN_W-1:0]  win_q, win_nxt;
    logic              en_q, en_nxt;
    logic [PSEL_W-1:0] psel_q, psel_nxt;

    ctrl_t wr;
    logic  win_open;
    logic  opener;
    logic  complete;
    logic  psel_take;

    always_comb begin
        wr       = unpack_ctrl(wr_data);
        win_open = (win_q != '0);
        opener   = wr_en && wr.chg && wr.en;
        complete = wr_en && win_open && !wr.chg;
    end

    // Enable bit: setting is always free below the locked level,
    // clearing needs a completing write, locked level pins it high.
    always_comb begin
        en_nxt = en_q;
        if (level == LVL_LOCKED) begin
            en_nxt = 1'b1;
        end else if (wr_en) begin
            if (wr.en)
                en_nxt = 1'b1;
            else if (complete)
                en_nxt = 1'b0;
        end
    end

    // Period select: free only at the open level
    always_comb begin
        psel_take = wr_en && ((level == LVL_OPEN) || complete);
        psel_nxt  = psel_take ? wr.psel : psel_q;
    end

    // Unlock window countdown
    always_comb begin
        if (opener)
            win_nxt = WIN_W'(UNLOCK_WINDOW);
        else if (complete)
            win_nxt = '0;
        else if (win_open)
            win_nxt = win_q - 1'b1;
        else
            win_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= (level == LVL_LOCKED);
            psel_q <= '0;
            win_q  <= '0;
        end else begin
            en_q   <= en_nxt;
            psel_q <= psel_nxt;
            win_q  <= win_nxt;
        end
    end

    assign restart = psel_take && (wr.psel != psel_q);

    always_comb begin
        ctrl.chg  = win_open;
        ctrl.en   = en_q || (level == LVL_LOCKED);
        ctrl.psel = psel_q;
    end

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_bypass
            assign tick = run && !clear;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] cnt_q;

            assign tick = run && !clear && (cnt_q == PW'(DIV - 1));

            always_ff @(posedge clk) begin
                if (rst || clear || !run)
                    cnt_q <= '0;
                else if (tick)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/wdog_timeout.sv
module wdog_timeout
    import wdog_pkg::*;
#(
    parameter int BASE_EXP = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              clear,
    input  logic              tick,
    input  logic [PSEL_W-1:0] psel,
    output logic              expire
);

    localparam int CNT_W = BASE_EXP + (1 << PSEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   cnt_inc;
    logic             hits;

    // One-hot limit 2^(BASE_EXP + psel)
    always_comb begin
        span = '0;
        span[BASE_EXP + int'(psel)] = 1'b1;
    end

    assign cnt_inc = {1'b0, cnt_q} + (CNT_W + 1)'(1);
    assign hits    = tick && (cnt_inc == span);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            expire <= 1'b0;
        end else begin
            expire <= run && !clear && hits;
            if (!run || clear || hits)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/wdog_guarded.sv
module wdog_guarded
    import wdog_pkg::*;
#(
    parameter int BASE_EXP  = 14,
    parameter int PRESC_DIV = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        level_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [CTRL_W-1:0] rd_data_o,
    input  logic              kick_i,
    output logic              wdt_reset_o
);

    level_e level;
    ctrl_t  ctrl;
    logic   restart;
    logic   clear;
    logic   tick;

    assign level = decode_level(level_i);

    wdog_ctrl_guard u_guard (
        .clk     (clk),
        .rst     (rst),
        .level   (level),
        .wr_en   (wr_en_i),
        .wr_data (wr_data_i),
        .ctrl    (ctrl),
        .restart (restart)
    );

    assign clear = kick_i || restart;

    wdog_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl.en),
        .clear (clear),
        .tick  (tick)
    );

    wdog_timeout #(.BASE_EXP(BASE_EXP)) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl.en),
        .clear  (clear),
        .tick   (tick),
        .psel   (ctrl.psel),
        .expire (wdt_reset_o)
    );

    assign rd_data_o = pack_ctrl(ctrl);

endmodule

// File: rtl/wdog_guarded_chk.sv
module wdog_guarded_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] level_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o,
    input logic       kick_i,
    input logic       wdt_reset_o
);

    logic [3:0] open_len;

    always_ff @(posedge clk) begin
        if (rst)
            open_len <= '0;
        else if (wr_en_i && wr_data_i[4] && wr_data_i[3])
            open_len <= '0;
        else if (rd_data_o[4])
            open_len <= open_len + 1'b1;
        else
            open_len <= '0;
    end

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_reset_o |=> !wdt_reset_o);

    // R11
    pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_reset_o |-> $past(rd_data_o[3]));

    // R7
    locked_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (level_i[1]) |-> rd_data_o[3]);

    // R3
    window_open_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data_o[4]) |-> $past(wr_en_i && wr_data_i[4] && wr_data_i[3]));

    // R3
    window_len_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[4] |-> (open_len < 4'd4));

    // R4
    disable_guard_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_data_o[3]) |-> $past(wr_en_i && rd_data_o[4] && !wr_data_i[4] && !wr_data_i[3]));

    // R6
    period_guard_chk: assert property (@(posedge clk) disable iff (rst)
        ((level_i != 2'd0) && !$stable(rd_data_o[2:0]))
            |-> $past(wr_en_i && rd_data_o[4] && !wr_data_i[4]));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[7:5] == 3'b000);

endmodule

bind wdog_guarded wdog_guarded_chk chk_i (.*);

// File: tb/wdog_guarded_tb_top.sv
module wdog_guarded_tb_top;

    localparam int BEXP = 2;
    localparam int PDIV = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] level_i = 2'd0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       kick_i = 1'b0;
    logic       wdt_reset_o;

    int vec_n  = 0;
    int miss_n = 0;

    always #4 clk = ~clk;

    wdog_guarded #(.BASE_EXP(BEXP), .PRESC_DIV(PDIV)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .level_i     (level_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .rd_data_o   (rd_data_o),
        .kick_i      (kick_i),
        .wdt_reset_o (wdt_reset_o)
    );

    function automatic int tmo_edges(input int psel);
        return (1 << (BEXP + psel)) * PDIV;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        vec_n++;
        if (act !== exp) begin
            miss_n++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        vec_n++;
        if (act !== exp) begin
            miss_n++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] lvl);
        @(negedge clk);
        rst = 1'b1; level_i = lvl; wr_en_i = 1'b0; kick_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en_i = 1'b1; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = 8'h00;
    endtask

    task automatic kick();
        kick_i = 1'b1;
        @(negedge clk);
        kick_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at the falling edge after the reference edge; pulse after ref+n.
    task automatic expect_pulse(input string req, input int n);
        int early = 0;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            if (wdt_reset_o) early++;
        end
        vec_n++;
        if (early != 0) begin
            miss_n++;
            $display("FAIL %s: early pulses got %0d expected 0", req, early);
        end
        @(negedge clk);
        check1(req, wdt_reset_o, 1'b1);
        @(negedge clk);
        check1(req, wdt_reset_o, 1'b0);
    endtask

    task automatic t_reset_values();
        do_reset(2'd0);
        check8("R1 level0", rd_data_o, 8'h00);
        check1("R1 no pulse", wdt_reset_o, 1'b0);
        do_reset(2'd1);
        check8("R1 level1", rd_data_o, 8'h00);
        do_reset(2'd2);
        check8("R1 level2", rd_data_o, 8'h08);
        do_reset(2'd3);
        check8("R1 R7 level3", rd_data_o, 8'h08);
    endtask

    task automatic t_level0();
        do_reset(2'd0);
        wr(8'hE8);
        check8("R2 R5 plain enable, top bits ignored", rd_data_o, 8'h08);
        wr(8'h0B);
        check8("R5 free period change", rd_data_o, 8'h0B);
        wr(8'h00);
        check8("R5 plain disable dropped", rd_data_o, 8'h08);
        wr(8'h18);
        check8("R3 window opens", rd_data_o, 8'h18);
        wr(8'h00);
        check8("R4 completing disable", rd_data_o, 8'h00);
    endtask

    task automatic t_window_edges();
        do_reset(2'd0);
        wr(8'h08);
        wr(8'h18);
        idle(3);
        check8("R3 still open third cycle", rd_data_o, 8'h18);
        wr(8'h00);
        check8("R4 completion in fourth cycle", rd_data_o, 8'h00);
        wr(8'h08);
        wr(8'h18);
        idle(4);
        check8("R3 window lapsed", rd_data_o, 8'h08);
        wr(8'h00);
        check8("R4 late disable dropped", rd_data_o, 8'h08);
    endtask

    task automatic t_level1();
        do_reset(2'd1);
        wr(8'h08);
        check8("R6 plain enable", rd_data_o, 8'h08);
        wr(8'h0A);
        check8("R6 plain period dropped", rd_data_o, 8'h08);
        wr(8'h1A);
        check8("R6 opener period not applied", rd_data_o, 8'h18);
        wr(8'h0A);
        check8("R6 completing period", rd_data_o, 8'h0A);
        wr(8'h02);
        check8("R6 plain disable dropped", rd_data_o, 8'h0A);
    endtask

    task automatic t_level2();
        do_reset(2'd2);
        wr(8'h00);
        check8("R7 disable dropped", rd_data_o, 8'h08);
        wr(8'h01);
        check8("R7 plain period dropped", rd_data_o, 8'h08);
        wr(8'h19);
        check8("R7 opener", rd_data_o, 8'h18);
        wr(8'h02);
        check8("R7 completion ignores enable", rd_data_o, 8'h0A);
    endtask

    task automatic t_timeout();
        do_reset(2'd0);
        wr(8'h08);
        expect_pulse("R8 first timeout", tmo_edges(0));
        expect_pulse("R8 repeat timeout", tmo_edges(0) - 1);
        do_reset(2'd0);
        wr(8'h09);
        expect_pulse("R8 period 1 timeout", tmo_edges(1));
    endtask

    task automatic t_kick();
        do_reset(2'd0);
        wr(8'h08);
        idle(5);
        kick();
        expect_pulse("R9 kick restarts", tmo_edges(0));
    endtask

    task automatic t_period_restart();
        do_reset(2'd0);
        wr(8'h08);
        idle(5);
        wr(8'h09);
        expect_pulse("R10 period change restarts", tmo_edges(1));
    endtask

    task automatic t_disabled();
        int hi = 0;
        do_reset(2'd0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (wdt_reset_o) hi++;
        end
        vec_n++;
        if (hi != 0) begin
            miss_n++;
            $display("FAIL R11 idle pulses: got %0d expected 0", hi);
        end
        wr(8'h08);
        idle(3);
        wr(8'h18);
        wr(8'h00);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (wdt_reset_o) hi++;
        end
        vec_n++;
        if (hi != 0) begin
            miss_n++;
            $display("FAIL R11 after disable pulses: got %0d expected 0", hi);
        end
    endtask

    initial begin
        t_reset_values();
        t_level0();
        t_window_edges();
        t_level1();
        t_level2();
        t_timeout();
        t_kick();
        t_period_restart();
        t_disabled();
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        vec_n++;
        miss_n++;
        $display("FAIL watchdog: run did not end got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
        $finish;
    end

endmodule